// File: doc/BRIEF.md
# PHY Auto-Negotiation Setup Sequencer

This block brings an Ethernet PHY from an unknown condition to a negotiated link. It does not drive the serial management wires. Instead it issues one register transaction at a time to a management master: register number, write flag and write data. It then waits for the master's completion pulse, which carries read data for reads. A `start` pulse launches the bring-up. A free-running millisecond tick paces the polling waits. The run ends with exactly one of three sticky flags: `done`, `failed` or `reset_timeout`.

The controller walks these states:
- `S_IDLE` goes to `S_RST_WR` on start.
- `S_RST_WR` issues the reset write and goes to `S_RST_RD`.
- `S_RST_RD` reads control. If the reset bit is clear it goes to `S_MASK_WR`. If the reset bit is still set it goes to `S_RST_WAIT`, or back to `S_IDLE` with a reset timeout when the attempts are used up.
- `S_RST_WAIT` returns to `S_RST_RD` once the interval elapses.
- `S_MASK_WR` goes to `S_CAP_RD`, which goes to `S_ADV_WR`, which goes to `S_AN_WR`, which goes to `S_POLL_RD`.
- `S_POLL_RD` goes to `S_IDLE` on completion or when the attempts are exhausted. Otherwise it goes to `S_RF_WR` on a remote fault, or to `S_POLL_WAIT` if there is none.
- `S_RF_WR` goes to `S_POLL_WAIT`.
- `S_POLL_WAIT` returns to `S_POLL_RD` once the interval elapses.

Parameters set the wait length in ticks (`POLL_MS`), the reset read limit (`RESET_TRIES`) and the status poll limit (`ANEG_TRIES`).

Top module: `aneg_setup_seq`

## Requirements
- R1: A start pulse in idle makes the first transaction a write of 0x8000 (bit 15, reset) to register 0.
- R2: Register 0 is then read, up to RESET_TRIES times. The sequence moves on at the first read with bit 15 clear. Consecutive reads are separated by POLL_MS ticks with no request outstanding. If every read shows bit 15 set, the run ends with `reset_timeout` high and no further transaction.
- R3: After reset clears, 0xFFFF is written to register 19, and then register 1 is read once to obtain the capabilities.
- R4: The word written next to register 4 has bit 0 set. Bits 9, 8, 7, 6 and 5 copy status bits 15, 14, 13, 12 and 11 of the capability read. Every other bit is zero.
- R5: Register 0 is then written with 0x1200 (bit 12 enable, bit 9 restart).
- R6: Register 1 is then polled, up to ANEG_TRIES times. Consecutive polls are separated by POLL_MS ticks with no request outstanding.
- R7: Suppose a poll shows no completion (bit 5 clear) but shows remote fault (bit 4 set), and it is not the last permitted poll. Then register 0 is written with 0x3300 (bits 13, 12, 9, 8) before the wait.
- R8: A poll with bit 5 set ends the run. It raises `done` if bit 4 is clear and `failed` if bit 4 is set. If the last permitted poll lacks bit 5, the run ends with `failed`. No transaction follows the end of a run.
- R9: A start pulse while a run is in progress is ignored.
- R10: After reset all three result flags are low. A result flag holds until the next start, which clears it, and at most one is high at a time.
- R11: `req_valid` with its register, write flag and data stays unchanged until the cycle in which `resp_done` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, honoured in idle only |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| req_valid | output | 1 | Transaction request to the management master |
| req_write | output | 1 | 1 for write, 0 for read |
| req_reg | output | 5 | PHY register number |
| req_wdata | output | 16 | Write data |
| resp_done | input | 1 | Completion pulse from the master |
| resp_rdata | input | 16 | Read data, valid with `resp_done` |
| done | output | 1 | Run finished with negotiation complete and no fault |
| failed | output | 1 | Negotiation timed out or ended with remote fault |
| reset_timeout | output | 1 | PHY reset never cleared |

## Verification
Negotiation completion and remote fault can arrive in the same status read. In that case the completion path must win: the run ends at once, without the forcing rewrite, yet the fault must still turn the result into `failed`. The bench provokes this by returning both bits in one poll. It expects the transaction log to stop at that poll with `failed` high. A second case puts the fault on the final permitted poll without completion, where the timeout and the fault rewrite compete. The bench requires the run to end with no rewrite.

// File: rtl/aneg_seq_pkg.sv
package aneg_seq_pkg;

    localparam int REG_AW = 5;
    localparam int DATA_W = 16;

    typedef logic [REG_AW-1:0] reg_addr_t;
    typedef logic [DATA_W-1:0] word_t;

    // PHY register numbers
    localparam reg_addr_t REG_CTRL  = 5'd0;
    localparam reg_addr_t REG_STAT  = 5'd1;
    localparam reg_addr_t REG_ADV   = 5'd4;
    localparam reg_addr_t REG_IMASK = 5'd19;

    // Control register bits
    localparam int CTL_RESET_BIT   = 15;
    localparam int CTL_SPEED_BIT   = 13;
    localparam int CTL_ANEN_BIT    = 12;
    localparam int CTL_RESTART_BIT = 9;
    localparam int CTL_DUPLEX_BIT  = 8;

    // Status register bits
    localparam int ST_ANDONE_BIT = 5;
    localparam int ST_RFAULT_BIT = 4;

    // Capability to advertisement mapping: status [CAP_HI -: N_CAP] -> adv [ADV_HI -: N_CAP]
    localparam int N_CAP       = 5;
    localparam int CAP_HI      = 15;
    localparam int ADV_HI      = 9;
    localparam int ADV_SEL_BIT = 0;

    localparam word_t CTL_RESET_CMD = word_t'(1 << CTL_RESET_BIT);
    localparam word_t AN_START_CMD  = word_t'((1 << CTL_ANEN_BIT) | (1 << CTL_RESTART_BIT));
    localparam word_t AN_FORCE_CMD  = word_t'((1 << CTL_ANEN_BIT) | (1 << CTL_RESTART_BIT) |
                                              (1 << CTL_SPEED_BIT) | (1 << CTL_DUPLEX_BIT));
    localparam word_t IMASK_ALL     = '1;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RST_WR,
        S_RST_RD,
        S_RST_WAIT,
        S_MASK_WR,
        S_CAP_RD,
        S_ADV_WR,
        S_AN_WR,
        S_POLL_RD,
        S_POLL_WAIT,
        S_RF_WR
    } seq_state_t;

endpackage

// File: rtl/aneg_interval_timer.sv
module aneg_interval_timer #(
    parameter int TICKS = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ms_tick,
    output logic expired
);
    localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    assign expired = run && ms_tick && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (ms_tick) begin
            cnt_q <= expired ? '0 : cnt_q + 1'b1;
        end
    end

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n) run |-> (cnt_q <= LAST)); // R6

endmodule

// File: rtl/aneg_attempt_counter.sv
module aneg_attempt_counter #(
    parameter int LIMIT_A = 6,
    parameter int LIMIT_B = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    input  logic phase_b,
    output logic at_last
);
    localparam int MAX_L = (LIMIT_A > LIMIT_B) ? LIMIT_A : LIMIT_B;
    localparam int AW    = (MAX_L < 2) ? 1 : $clog2(MAX_L + 1);
    localparam logic [AW-1:0] LAST_A = AW'(LIMIT_A - 1);
    localparam logic [AW-1:0] LAST_B = AW'(LIMIT_B - 1);

    logic [AW-1:0] cnt_q;
    logic [AW-1:0] last_sel;

    assign last_sel = phase_b ? LAST_B : LAST_A;
    assign at_last  = (cnt_q == last_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_ATTEMPT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) !clr |-> (cnt_q <= last_sel)); // R2

endmodule

// File: rtl/aneg_adv_builder.sv
module aneg_adv_builder
    import aneg_seq_pkg::*;
(
    input  logic [15:0] caps,
    output logic [15:0] adv
);
    always_comb begin
        adv = '0;
        adv[ADV_SEL_BIT] = 1'b1;
        for (int k = 0; k < N_CAP; k++) begin
            adv[ADV_HI - k] = caps[CAP_HI - k];
        end
    end

endmodule

// File: rtl/aneg_setup_seq.sv
module aneg_setup_seq
    import aneg_seq_pkg::*;
#(
    parameter int POLL_MS     = 500,
    parameter int RESET_TRIES = 6,
    parameter int ANEG_TRIES  = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        ms_tick,
    output logic        req_valid,
    output logic        req_write,
    output logic [4:0]  req_reg,
    output logic [15:0] req_wdata,
    input  logic        resp_done,
    input  logic [15:0] resp_rdata,
    output logic        done,
    output logic        failed,
    output logic        reset_timeout
);
    seq_state_t state_q, state_d;

    word_t caps_q;
    word_t adv_w;
    logic  wait_run, wait_exp;
    logic  cnt_clr, cnt_step, cnt_poll, cnt_last;
    logic  fin_ok, fin_fail, fin_rt;

    // ---------------- helpers ----------------
    assign wait_run = (state_q == S_RST_WAIT) || (state_q == S_POLL_WAIT);
    assign cnt_poll = (state_q inside {S_POLL_RD, S_POLL_WAIT, S_RF_WR});
    assign cnt_clr  = !(state_q inside {S_RST_RD, S_RST_WAIT, S_POLL_RD, S_POLL_WAIT, S_RF_WR});

    aneg_interval_timer #(.TICKS(POLL_MS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (wait_run),
        .ms_tick (ms_tick),
        .expired (wait_exp)
    );

    aneg_attempt_counter #(.LIMIT_A(RESET_TRIES), .LIMIT_B(ANEG_TRIES)) u_attempts (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .step    (cnt_step),
        .phase_b (cnt_poll),
        .at_last (cnt_last)
    );

    aneg_adv_builder u_adv (
        .caps (caps_q),
        .adv  (adv_w)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d  = state_q;
        fin_ok   = 1'b0;
        fin_fail = 1'b0;
        fin_rt   = 1'b0;
        cnt_step = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) state_d = S_RST_WR;
            end
            S_RST_WR: begin
                if (resp_done) state_d = S_RST_RD;
            end
            S_RST_RD: begin
                if (resp_done) begin
                    if (!resp_rdata[CTL_RESET_BIT]) begin
                        state_d = S_MASK_WR;
                    end else if (cnt_last) begin
                        state_d = S_IDLE;
                        fin_rt  = 1'b1;
                    end else begin
                        state_d  = S_RST_WAIT;
                        cnt_step = 1'b1;
                    end
                end
            end
            S_RST_WAIT: begin
                if (wait_exp) state_d = S_RST_RD;
            end
            S_MASK_WR: begin
                if (resp_done) state_d = S_CAP_RD;
            end
            S_CAP_RD: begin
                if (resp_done) state_d = S_ADV_WR;
            end
            S_ADV_WR: begin
                if (resp_done) state_d = S_AN_WR;
            end
            S_AN_WR: begin
                if (resp_done) state_d = S_POLL_RD;
            end
            S_POLL_RD: begin
                if (resp_done) begin
                    if (resp_rdata[ST_ANDONE_BIT]) begin
                        state_d = S_IDLE;
                        if (resp_rdata[ST_RFAULT_BIT]) fin_fail = 1'b1;
                        else                           fin_ok   = 1'b1;
                    end else if (cnt_last) begin
                        state_d  = S_IDLE;
                        fin_fail = 1'b1;
                    end else begin
                        cnt_step = 1'b1;
                        state_d  = resp_rdata[ST_RFAULT_BIT] ? S_RF_WR : S_POLL_WAIT;
                    end
                end
            end
            S_RF_WR: begin
                if (resp_done) state_d = S_POLL_WAIT;
            end
            S_POLL_WAIT: begin
                if (wait_exp) state_d = S_POLL_RD;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // ---------------- request outputs ----------------
    always_comb begin
        req_valid = 1'b0;
        req_write = 1'b0;
        req_reg   = REG_CTRL;
        req_wdata = '0;
        unique case (state_q)
            S_RST_WR: begin
                req_valid = 1'b1;
                req_write = 1'b1;
                req_wdata = CTL_RESET_CMD;
            end
            S_RST_RD: begin
                req_valid = 1'b1;
            end
            S_MASK_WR: begin
                req_valid = 1'b1;
                req_write = 1'b1;
                req_reg   = REG_IMASK;
                req_wdata = IMASK_ALL;
            end
            S_CAP_RD: begin
                req_valid = 1'b1;
                req_reg   = REG_STAT;
            end
            S_ADV_WR: begin
                req_valid = 1'b1;
                req_write = 1'b1;
                req_reg   = REG_ADV;
                req_wdata = adv_w;
            end
            S_AN_WR: begin
                req_valid = 1'b1;
                req_write = 1'b1;
                req_wdata = AN_START_CMD;
            end
            S_POLL_RD: begin
                req_valid = 1'b1;
                req_reg   = REG_STAT;
            end
            S_RF_WR: begin
                req_valid = 1'b1;
                req_write = 1'b1;
                req_wdata = AN_FORCE_CMD;
            end
            default: ;
        endcase
    end

    // ---------------- captured capabilities and results ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            caps_q <= '0;
        end else if (state_q == S_CAP_RD && resp_done) begin
            caps_q <= resp_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done          <= 1'b0;
            failed        <= 1'b0;
            reset_timeout <= 1'b0;
        end else if (state_q == S_IDLE && start) begin
            done          <= 1'b0;
            failed        <= 1'b0;
            reset_timeout <= 1'b0;
        end else begin
            if (fin_ok)   done          <= 1'b1;
            if (fin_fail) failed        <= 1'b1;
            if (fin_rt)   reset_timeout <= 1'b1;
        end
    end

    // ---------------- assertions ----------------
    AST_FIRST_TXN_RESET: assert property (@(posedge clk) disable iff (!rst_n) (state_q == S_IDLE && start) |=> (req_valid && req_write && req_reg == REG_CTRL && req_wdata == CTL_RESET_CMD)); // R1
    AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_write && req_reg == REG_IMASK) |-> (req_wdata == IMASK_ALL)); // R3
    AST_ADV_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_write && req_reg == REG_ADV) |-> (req_wdata[0] && req_wdata[4:1] == 4'd0 && req_wdata[15:10] == 6'd0)); // R4
    AST_RESULT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (done || failed || reset_timeout) |-> (state_q == S_IDLE && !req_valid)); // R8
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (state_q != S_IDLE && state_q != S_RST_WR && start) |=> !(req_valid && req_write && req_reg == REG_CTRL && req_wdata == CTL_RESET_CMD)); // R9
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({done, failed, reset_timeout})); // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (state_q == S_IDLE && !start) |=> $stable({done, failed, reset_timeout})); // R10
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && !resp_done) |=> (req_valid && $stable(req_write) && $stable(req_reg) && $stable(req_wdata))); // R11

endmodule

// File: tb/tb_aneg_setup_seq.sv
module tb_aneg_setup_seq;
    localparam int CLK_PERIOD = 10;
    localparam int P_MS = 3;
    localparam int RT   = 4;
    localparam int AT   = 5;
    localparam int LAT  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic ms_tick = 1'b0;
    logic resp_done = 1'b0;
    logic [15:0] resp_rdata = 16'h0;
    logic req_valid, req_write;
    logic [4:0] req_reg;
    logic [15:0] req_wdata;
    logic done, failed, reset_timeout;

    aneg_setup_seq #(.POLL_MS(P_MS), .RESET_TRIES(RT), .ANEG_TRIES(AT)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ms_tick(ms_tick),
        .req_valid(req_valid), .req_write(req_write), .req_reg(req_reg), .req_wdata(req_wdata),
        .resp_done(resp_done), .resp_rdata(resp_rdata),
        .done(done), .failed(failed), .reset_timeout(reset_timeout)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // scenario
    logic [15:0] sc_caps;
    int          sc_busy, sc_dp;
    logic [31:0] sc_rf;
    int rr, s1, lg_n, idle_cnt;
    logic        lg_wr   [64];
    logic [4:0]  lg_reg  [64];
    logic [15:0] lg_data [64];
    int          lg_idle [64];
    logic        exp_wr   [64];
    logic [4:0]  exp_reg  [64];
    logic [15:0] exp_data [64];
    int          exp_idle [64];
    string       exp_tag  [64];
    int exp_n, exp_out;

    // millisecond tick: two of every three cycles, changed just after the edge
    int tick_ph = 0;
    initial begin
        forever begin
            @(posedge clk);
            #1;
            tick_ph = (tick_ph + 1) % 3;
            ms_tick = (tick_ph != 0);
        end
    end

    // management master model
    bit pend = 1'b0;
    int lat  = 0;
    int cur  = 0;
    int pidx = 0;
    initial begin
        idle_cnt = 0;
        lg_n = 0;
        rr = 0;
        s1 = 0;
        forever begin
            @(negedge clk);
            resp_done = 1'b0;
            if (!rst_n) begin
                pend = 1'b0;
            end else if (pend) begin
                lat--;
                if (lat == 0) begin
                    // R11: request unchanged up to the completion
                    check(req_valid && req_write == lg_wr[cur] && req_reg == lg_reg[cur] && req_wdata == lg_data[cur],
                          "R11", "request held until response",
                          {10'd0, req_valid, req_reg, req_wdata}, {10'd0, 1'b1, lg_reg[cur], lg_data[cur]});
                    resp_done = 1'b1;
                    pend = 1'b0;
                end
            end else if (req_valid) begin
                cur = (lg_n < 64) ? lg_n : 63;
                lg_wr[cur]   = req_write;
                lg_reg[cur]  = req_reg;
                lg_data[cur] = req_wdata;
                lg_idle[cur] = idle_cnt;
                idle_cnt = 0;
                if (lg_n < 64) lg_n++;
                if (req_write) begin
                    resp_rdata = 16'hA5C3;
                end else if (req_reg == 5'd0) begin
                    resp_rdata = ((rr < sc_busy) ? 16'h8000 : 16'h0000) | 16'h2100;
                    rr++;
                end else if (req_reg == 5'd1) begin
                    if (s1 == 0) begin
                        resp_rdata = sc_caps | 16'h0031;
                    end else begin
                        pidx = s1 - 1;
                        resp_rdata = 16'h7800 | ((pidx >= sc_dp) ? 16'h0020 : 16'h0000) |
                                     ((pidx < 32 && sc_rf[pidx]) ? 16'h0010 : 16'h0000);
                    end
                    s1++;
                end else begin
                    resp_rdata = 16'h0000;
                end
                pend = 1'b1;
                lat = LAT;
            end else if (ms_tick) begin
                idle_cnt++;
            end
        end
    end

    task automatic add_exp(input bit wr, input logic [4:0] r, input logic [15:0] d,
                           input string tag, input int idle);
        if (exp_n < 64) begin
            exp_wr[exp_n]   = wr;
            exp_reg[exp_n]  = r;
            exp_data[exp_n] = d;
            exp_tag[exp_n]  = tag;
            exp_idle[exp_n] = idle;
            exp_n++;
        end
    endtask

    task automatic build_expected();
        logic [15:0] adv;
        exp_n = 0;
        add_exp(1'b1, 5'd0, 16'h8000, "R1", -1);
        for (int i = 0; i < RT; i++) begin
            add_exp(1'b0, 5'd0, 16'h0, "R2", (i > 0) ? P_MS : -1);
            if (i >= sc_busy) break;
            if (i == RT - 1) begin
                exp_out = 2;
                return;
            end
        end
        add_exp(1'b1, 5'd19, 16'hFFFF, "R3", -1);
        add_exp(1'b0, 5'd1, 16'h0, "R3", -1);
        adv = 16'h0001;
        for (int k = 0; k < 5; k++) if (sc_caps[15 - k]) adv[9 - k] = 1'b1;
        add_exp(1'b1, 5'd4, adv, "R4", -1);
        add_exp(1'b1, 5'd0, 16'h1200, "R5", -1);
        for (int p = 0; p < AT; p++) begin
            add_exp(1'b0, 5'd1, 16'h0, "R6", (p > 0) ? P_MS : -1);
            if (p >= sc_dp) begin
                exp_out = sc_rf[p] ? 1 : 0;
                return;
            end
            if (p == AT - 1) begin
                exp_out = 1;
                return;
            end
            if (sc_rf[p]) add_exp(1'b1, 5'd0, 16'h3300, "R7", -1);
        end
    endtask

    task automatic run_case(input logic [15:0] caps, input int busy, input int dp,
                            input logic [31:0] rf, input bit poke);
        int cyc;
        int n0;
        logic [2:0] res0, exp_res;
        @(negedge clk);
        sc_caps = caps;
        sc_busy = busy;
        sc_dp = dp;
        sc_rf = rf;
        rr = 0;
        s1 = 0;
        lg_n = 0;
        build_expected();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!done && !failed && !reset_timeout, "R10", "start clears result flags",
              {29'd0, reset_timeout, failed, done}, 32'd0);
        cyc = 0;
        while (!(done || failed || reset_timeout) && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            start = (poke && cyc == 20);   // R9: start while running
        end
        start = 1'b0;
        check(cyc < 3000, "R8", "run reaches an end", cyc, 3000);
        exp_res = (exp_out == 0) ? 3'b001 : (exp_out == 1) ? 3'b010 : 3'b100;
        check({reset_timeout, failed, done} == exp_res, (exp_out == 2) ? "R2" : "R8", "result flags",
              {29'd0, reset_timeout, failed, done}, {29'd0, exp_res});
        for (int i = 0; i < exp_n && i < lg_n; i++) begin
            check(lg_wr[i] == exp_wr[i] && lg_reg[i] == exp_reg[i] && (!exp_wr[i] || lg_data[i] == exp_data[i]),
                  exp_tag[i], $sformatf("transaction %0d", i),
                  {11'd0, lg_wr[i], lg_reg[i], lg_data[i]}, {11'd0, exp_wr[i], exp_reg[i], exp_data[i]});
            if (exp_idle[i] >= 0)
                check(lg_idle[i] == exp_idle[i], exp_tag[i], $sformatf("ticks before transaction %0d", i),
                      lg_idle[i], exp_idle[i]);
        end
        check(lg_n == exp_n, (exp_out == 2) ? "R2" : "R8", "transaction count", lg_n, exp_n);
        // R10: results hold, nothing more is issued
        n0 = lg_n;
        res0 = {reset_timeout, failed, done};
        repeat (8) @(negedge clk);
        check({reset_timeout, failed, done} == res0 && !req_valid && lg_n == n0, "R10", "idle hold after run",
              {28'd0, req_valid, reset_timeout, failed, done}, {28'd0, 1'b0, res0});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !failed && !reset_timeout && !req_valid, "R10", "state after reset",
              {28'd0, req_valid, reset_timeout, failed, done}, 32'd0);
        // R4: every capability combination
        for (int c = 0; c < 32; c++) run_case(16'(c << 11), 1, 1, 32'h0, 1'b0);
        // R2: reset clears after 0..RT-1 busy reads, or never
        for (int b = 0; b <= RT; b++) run_case(16'hF800, b, 0, 32'h0, 1'b0);
        // R6/R8: completion at each poll, or never
        for (int d = 0; d <= AT; d++) run_case(16'h5000, 0, d, 32'h0, 1'b0);
        // R7: remote fault restarts
        run_case(16'hA800, 0, 2, 32'h1, 1'b0);
        run_case(16'h0800, 1, 3, 32'h3, 1'b0);
        // R8: completion and fault in the same read
        run_case(16'hF800, 0, 2, 32'h4, 1'b0);
        // R8: fault on the last permitted poll, no rewrite
        run_case(16'hF800, 0, AT, 32'(1 << (AT - 1)), 1'b0);
        // R9: start during a run
        run_case(16'h3000, 2, 3, 32'h0, 1'b1);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule